// File: doc/BRIEF.md
# Reference Oscillator Disciplining Loop

This block keeps a voltage-tuned reference oscillator on frequency. When an external reference is present, it steers the oscillator from phase-error samples that an external phase-frequency detector and ADC produce. The block clocks from the oscillator it steers, nominally 20 MHz, against a 10 MHz external reference. Each accepted sample passes through a proportional-plus-integral loop filter whose output code sets the duty cycle of a PWM DAC. The filtered PWM output is the oscillator's tuning voltage.

A monitor watches a synchronous pulse that marks each reference edge. If no pulse arrives within a programmable number of oscillator cycles, the monitor declares the reference lost. The tuning code then comes from a held code plus a signed manual trim. Once the phase error has stayed small for a set number of consecutive samples, the block asks the nonvolatile store to save the current code, using a request/acknowledge pair. It also keeps that code as the holdover value. When the reference returns, the integrator starts from the holdover code, so the tuning voltage does not step.

Top module: `osc_discipline`

## Requirements
- R1: After reset, ref_ok_o, stable_o and save_req_o are 0, and dac_code_o equals mid-scale (2^(DAC_W-1)).
- R2: ref_ok_o goes high on the clock edge that samples ref_edge_i high. It goes low on the (timeout_i+1)-th edge after the last edge that sampled ref_edge_i high, counting only edges where ref_edge_i is low.
- R3: A sample is accepted when err_valid_i is high and ref_ok_o is high. Each accepted sample (err_i is two's complement) sets integ = clamp(integ + (err_i >>> KI_SHIFT)). On the same edge, dac_code_o becomes clamp(integ_new + (err_i >>> KP_SHIFT)). The clamp range is [0, 2^DAC_W-1].
- R4: While ref_ok_o is low, samples are ignored: they change neither dac_code_o nor stable_o, and they raise no save request.
- R5: While ref_ok_o is low, dac_code_o equals clamp(hold + trim_i), where trim_i is two's complement of DAC_W bits. hold starts at mid-scale.
- R6: While ref_ok_o is high, trim_i has no effect on dac_code_o.
- R7: stable_o is high when the last STABLE_N accepted samples all had |err_i| < THRESH. A larger sample or a loss of reference clears it.
- R8: One cycle after stable_o rises, save_req_o goes high and save_code_o carries the current dac_code_o, which also becomes hold. The request stays high with its code unchanged until save_ack_i is sampled high.
- R9: At most one save request is issued per stable period. A new request needs stable_o to fall and rise again.
- R10: The first reference pulse while ref_ok_o is low loads the integrator and output with clamp(hold + trim_i), so dac_code_o does not change as ref_ok_o rises.
- R11: pwm_o has a period of 2^DAC_W cycles and is high for dac_code_o cycles in each period. The duty value is taken at the period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Steered oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_valid_i | input | 1 | Phase-error sample strobe |
| err_i | input | ERR_W | Signed phase-error sample |
| ref_edge_i | input | 1 | Synchronous pulse marking a reference edge |
| timeout_i | input | TO_W | Loss timeout in clock cycles |
| trim_i | input | DAC_W | Signed manual offset applied in holdover |
| save_ack_i | input | 1 | Store acknowledges the save request |
| save_req_o | output | 1 | Save request to the nonvolatile store |
| save_code_o | output | DAC_W | Code to store |
| ref_ok_o | output | 1 | External reference present |
| stable_o | output | 1 | Loop judged stable |
| dac_code_o | output | DAC_W | Active tuning code |
| pwm_o | output | 1 | PWM DAC output |

## Verification
The bench builds the block with DAC_W=8, ERR_W=12, KP_SHIFT=1, KI_SHIFT=2, STABLE_N=4 and THRESH=16, with timeout_i set to 10. The 8-bit code makes the PWM period 256 cycles, so duty can be counted over two whole periods. The shifts give hand-computable filter steps that reach both clamp rails within a few samples. Four stable samples are enough to reach the save request, its once-per-period rule and a second stable period in a short run. The timeout of 10 puts the loss edge at a known cycle.

// File: rtl/osc_disc_pkg.sv
package osc_disc_pkg;

  function automatic int unsigned wmax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/osc_ref_monitor.sv
module osc_ref_monitor #(
  parameter int unsigned TO_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            edge_i,
  input  logic [TO_W-1:0] timeout_i,
  output logic            ok_o,
  output logic            acquire_o
);

  logic [TO_W-1:0] idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= '0;
      ok_o   <= 1'b0;
    end else if (edge_i) begin
      idle_q <= '0;
      ok_o   <= 1'b1;
    end else if (idle_q != timeout_i) begin
      idle_q <= idle_q + 1'b1;
    end else begin
      ok_o <= 1'b0;
    end
  end

  // first reference pulse while lost: preload the loop this edge
  assign acquire_o = edge_i & ~ok_o;

endmodule

// File: rtl/osc_loop_filter.sv
module osc_loop_filter import osc_disc_pkg::*; #(
  parameter int unsigned DAC_W    = 16,
  parameter int unsigned ERR_W    = 16,
  parameter int unsigned KP_SHIFT = 4,
  parameter int unsigned KI_SHIFT = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sample_i,
  input  logic signed [ERR_W-1:0] err_i,
  input  logic                    preload_i,
  input  logic [DAC_W-1:0]        preload_code_i,
  output logic [DAC_W-1:0]        code_o
);

  localparam int unsigned SUM_W = wmax(DAC_W, ERR_W) + 2;
  localparam logic [DAC_W-1:0] MID = {1'b1, {(DAC_W-1){1'b0}}};
  localparam logic signed [SUM_W-1:0] MAXV = {{(SUM_W-DAC_W){1'b0}}, {DAC_W{1'b1}}};

  function automatic logic [DAC_W-1:0] sat(input logic signed [SUM_W-1:0] v);
    if (v < 0)          return '0;
    else if (v > MAXV)  return '1;
    else                return v[DAC_W-1:0];
  endfunction

  logic [DAC_W-1:0]        integ_q;
  logic signed [SUM_W-1:0] err_ext, ki_term, kp_term, integ_sum, prop_sum;
  logic [DAC_W-1:0]        integ_nxt, code_nxt;

  always_comb begin
    err_ext   = {{(SUM_W-ERR_W){err_i[ERR_W-1]}}, err_i};
    ki_term   = err_ext >>> KI_SHIFT;
    kp_term   = err_ext >>> KP_SHIFT;
    integ_sum = $signed({{(SUM_W-DAC_W){1'b0}}, integ_q}) + ki_term;
    integ_nxt = sat(integ_sum);
    prop_sum  = $signed({{(SUM_W-DAC_W){1'b0}}, integ_nxt}) + kp_term;
    code_nxt  = sat(prop_sum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      integ_q <= MID;
      code_o  <= MID;
    end else if (preload_i) begin
      integ_q <= preload_code_i;
      code_o  <= preload_code_i;
    end else if (sample_i) begin
      integ_q <= integ_nxt;
      code_o  <= code_nxt;
    end
  end

endmodule

// File: rtl/osc_lock_detect.sv
module osc_lock_detect #(
  parameter int unsigned ERR_W    = 16,
  parameter int unsigned STABLE_N = 64,
  parameter int unsigned THRESH   = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sample_i,
  input  logic signed [ERR_W-1:0] err_i,
  input  logic                    ref_ok_i,
  output logic                    stable_o
);

  localparam int unsigned CNT_W = $clog2(STABLE_N + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(STABLE_N);
  localparam logic [ERR_W:0]   LIM  = (ERR_W+1)'(THRESH);

  logic [CNT_W-1:0] run_q;
  logic [ERR_W:0]   mag;

  always_comb begin
    if (err_i[ERR_W-1]) mag = -{err_i[ERR_W-1], err_i};
    else                mag = {1'b0, err_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (!ref_ok_i) begin
      run_q <= '0;
    end else if (sample_i) begin
      if (mag >= LIM)         run_q <= '0;
      else if (run_q != FULL) run_q <= run_q + 1'b1;
    end
  end

  assign stable_o = (run_q == FULL) & ref_ok_i;

endmodule

// File: rtl/osc_pwm.sv
module osc_pwm #(
  parameter int unsigned DAC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DAC_W-1:0] code_i,
  output logic             pwm_o
);

  logic [DAC_W-1:0] phase_q, duty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      duty_q  <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
      if (phase_q == '1) duty_q <= code_i;  // glitch-free duty update
    end
  end

  assign pwm_o = phase_q < duty_q;

endmodule

// File: rtl/osc_discipline.sv
module osc_discipline #(
  parameter int unsigned DAC_W    = 16,
  parameter int unsigned ERR_W    = 16,
  parameter int unsigned TO_W     = 16,
  parameter int unsigned KP_SHIFT = 4,
  parameter int unsigned KI_SHIFT = 8,
  parameter int unsigned STABLE_N = 64,
  parameter int unsigned THRESH   = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    err_valid_i,
  input  logic signed [ERR_W-1:0] err_i,
  input  logic                    ref_edge_i,
  input  logic [TO_W-1:0]         timeout_i,
  input  logic signed [DAC_W-1:0] trim_i,
  input  logic                    save_ack_i,
  output logic                    save_req_o,
  output logic [DAC_W-1:0]        save_code_o,
  output logic                    ref_ok_o,
  output logic                    stable_o,
  output logic [DAC_W-1:0]        dac_code_o,
  output logic                    pwm_o
);

  localparam int unsigned HW = DAC_W + 2;
  localparam logic [DAC_W-1:0] MID = {1'b1, {(DAC_W-1){1'b0}}};
  localparam logic signed [HW-1:0] HMAX = {2'b00, {DAC_W{1'b1}}};

  logic             acquire, sample, stable_q;
  logic [DAC_W-1:0] loop_code, hold_q, hold_code;
  logic signed [HW-1:0] hold_sum;

  osc_ref_monitor #(.TO_W(TO_W)) u_mon (
    .clk_i, .rst_ni,
    .edge_i    (ref_edge_i),
    .timeout_i (timeout_i),
    .ok_o      (ref_ok_o),
    .acquire_o (acquire)
  );

  assign sample = err_valid_i & ref_ok_o;

  always_comb begin
    hold_sum = $signed({2'b00, hold_q}) + $signed({{2{trim_i[DAC_W-1]}}, trim_i});
    if (hold_sum < 0)         hold_code = '0;
    else if (hold_sum > HMAX) hold_code = '1;
    else                      hold_code = hold_sum[DAC_W-1:0];
  end

  osc_loop_filter #(
    .DAC_W(DAC_W), .ERR_W(ERR_W), .KP_SHIFT(KP_SHIFT), .KI_SHIFT(KI_SHIFT)
  ) u_filt (
    .clk_i, .rst_ni,
    .sample_i       (sample),
    .err_i          (err_i),
    .preload_i      (acquire),
    .preload_code_i (hold_code),
    .code_o         (loop_code)
  );

  osc_lock_detect #(
    .ERR_W(ERR_W), .STABLE_N(STABLE_N), .THRESH(THRESH)
  ) u_lock (
    .clk_i, .rst_ni,
    .sample_i (sample),
    .err_i    (err_i),
    .ref_ok_i (ref_ok_o),
    .stable_o (stable_o)
  );

  assign dac_code_o = ref_ok_o ? loop_code : hold_code;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stable_q    <= 1'b0;
      save_req_o  <= 1'b0;
      save_code_o <= '0;
      hold_q      <= MID;
    end else begin
      stable_q <= stable_o;
      if (save_req_o) begin
        if (save_ack_i) save_req_o <= 1'b0;
      end else if (stable_o && !stable_q) begin
        save_req_o  <= 1'b1;
        save_code_o <= loop_code;
        hold_q      <= loop_code;
      end
    end
  end

  osc_pwm #(.DAC_W(DAC_W)) u_pwm (
    .clk_i, .rst_ni,
    .code_i (dac_code_o),
    .pwm_o  (pwm_o)
  );

endmodule

// File: rtl/osc_discipline_chk.sv
module osc_discipline_chk #(
  parameter int unsigned DAC_W = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic signed [DAC_W-1:0] trim_i,
  input logic                    save_ack_i,
  input logic                    save_req_o,
  input logic [DAC_W-1:0]        save_code_o,
  input logic                    ref_ok_o,
  input logic                    stable_o,
  input logic [DAC_W-1:0]        dac_code_o
);

  AST_SAVE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_req_o && !save_ack_i |=> save_req_o); // R8

  AST_SAVE_CODE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_req_o && !save_ack_i |=> $stable(save_code_o)); // R8

  AST_SAVE_NEEDS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(save_req_o) |-> stable_o); // R9

  AST_LOSS_CLEARS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_ok_o |-> !stable_o); // R7

  AST_HOLDOVER_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_ok_o && $past(!ref_ok_o) && $stable(trim_i) |-> $stable(dac_code_o)); // R5

  AST_REACQ_NO_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ref_ok_o) && $stable(trim_i) |-> $stable(dac_code_o)); // R10

endmodule

bind osc_discipline osc_discipline_chk #(.DAC_W(DAC_W)) u_chk (.*);

// File: tb/tb_osc_discipline.sv
`timescale 1ns/1ps
module tb_osc_discipline;

  localparam int unsigned DAC_W = 8;
  localparam int unsigned ERR_W = 12;
  localparam int unsigned TO_W  = 8;
  localparam int unsigned TOUT  = 10;
  localparam int NV = 9;
  localparam int V_ERR  [NV] = '{40, -80, 800, -2000, 100, 0, 4, -4, 8};
  localparam int V_CODE [NV] = '{158, 78, 255, 0, 75, 25, 28, 23, 31};
  localparam int V_STB  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic err_valid = 1'b0, ref_edge = 1'b0, save_ack = 1'b0;
  logic signed [ERR_W-1:0] err = '0;
  logic [TO_W-1:0] timeout = TO_W'(TOUT);
  logic signed [DAC_W-1:0] trim = '0;
  logic save_req, ref_ok, stable, pwm;
  logic [DAC_W-1:0] save_code, dac_code;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  osc_discipline #(
    .DAC_W(DAC_W), .ERR_W(ERR_W), .TO_W(TO_W),
    .KP_SHIFT(1), .KI_SHIFT(2), .STABLE_N(4), .THRESH(16)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .err_valid_i(err_valid), .err_i(err),
    .ref_edge_i(ref_edge), .timeout_i(timeout), .trim_i(trim),
    .save_ack_i(save_ack), .save_req_o(save_req), .save_code_o(save_code),
    .ref_ok_o(ref_ok), .stable_o(stable), .dac_code_o(dac_code), .pwm_o(pwm)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int e);
    err_valid = 1'b1;
    err = ERR_W'(e);
    @(negedge clk);
    err_valid = 1'b0;
  endtask

  task automatic ack();
    save_ack = 1'b1;
    @(negedge clk);
    save_ack = 1'b0;
  endtask

  task automatic pwm_count(output int n);
    n = 0;
    repeat (300) @(negedge clk);
    for (int i = 0; i < 512; i++) begin
      if (pwm) n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ref_ok", int'(ref_ok), 0);
    chk("R1 stable", int'(stable), 0);
    chk("R1 save_req", int'(save_req), 0);
    chk("R1 dac_code", int'(dac_code), 128);

    // acquire: preload from hold (128) + trim 0
    ref_edge = 1'b1;
    @(negedge clk);
    chk("R2 ref_ok rise", int'(ref_ok), 1);
    chk("R10 acquire code", int'(dac_code), 128);

    // R3 R7 filter table
    for (int i = 0; i < NV; i++) begin
      send(V_ERR[i]);
      chk("R3 code", int'(dac_code), V_CODE[i]);
      chk("R7 stable", int'(stable), V_STB[i]);
    end
    chk("R8 no req same cycle", int'(save_req), 0);
    @(negedge clk);
    chk("R8 save_req", int'(save_req), 1);
    chk("R8 save_code", int'(save_code), 31);
    repeat (2) @(negedge clk);
    chk("R8 req held", int'(save_req), 1);
    ack();
    chk("R8 req cleared", int'(save_req), 0);

    // R9 still stable, no second request
    for (int i = 0; i < 3; i++) send(0);
    chk("R9 code", int'(dac_code), 27);
    chk("R9 stable", int'(stable), 1);
    @(negedge clk);
    chk("R9 no repeat req", int'(save_req), 0);
    send(100);
    chk("R7 large clears", int'(stable), 0);
    chk("R3 code", int'(dac_code), 102);
    for (int i = 0; i < 4; i++) send(0);
    chk("R7 stable again", int'(stable), 1);
    @(negedge clk);
    chk("R9 new period req", int'(save_req), 1);
    chk("R9 new code", int'(save_code), 52);
    ack();

    // R6 trim ignored while locked
    trim = 8'sd5;
    @(negedge clk);
    chk("R6 trim ignored", int'(dac_code), 52);

    // R2 loss timing
    ref_edge = 1'b0;
    repeat (TOUT) @(negedge clk);
    chk("R2 ok before timeout", int'(ref_ok), 1);
    @(negedge clk);
    chk("R2 ok after timeout", int'(ref_ok), 0);
    chk("R7 loss clears", int'(stable), 0);
    chk("R5 holdover code", int'(dac_code), 57);

    // R4 samples ignored in holdover
    for (int i = 0; i < 5; i++) send(4);
    chk("R4 code", int'(dac_code), 57);
    chk("R4 stable", int'(stable), 0);
    @(negedge clk);
    chk("R4 no req", int'(save_req), 0);

    trim = -8'sd60;
    @(negedge clk);
    chk("R5 clamp low", int'(dac_code), 0);
    pwm_count(n);
    chk("R11 duty 0", n, 0);
    trim = 8'sd5;
    @(negedge clk);
    chk("R5 trim back", int'(dac_code), 57);
    pwm_count(n);
    chk("R11 duty 57", n, 114);

    // R10 reacquire without jump
    ref_edge = 1'b1;
    @(negedge clk);
    chk("R2 reacquire", int'(ref_ok), 1);
    chk("R10 no jump", int'(dac_code), 57);
    send(8);
    chk("R10 integ preloaded", int'(dac_code), 63);
    trim = 8'sd100;
    @(negedge clk);
    chk("R6 trim ignored", int'(dac_code), 63);

    done = 1'b1;
    finish_sim();
  end

endmodule